// File: doc/BRIEF.md
# Vector Lane Interleave Permute Unit

This unit performs the two-register lane shuffles of a 128-bit SIMD pipeline. Each cycle it may accept two 128-bit operands, called A and B, and a 32-bit instruction word. It decodes the word into one of three permutations: interleave (zip), de-interleave (unzip) or transpose. Each permutation works on 8-, 16- or 32-bit elements. Every legal operation produces two full 128-bit results at once. Result A is meant for the register that supplied A, and result B for the register that supplied B.

The shuffle network is purely combinational: three width-specific lane shuffles followed by a size select. A single output register stage follows it. Instruction words whose encoding matches no permutation are dropped. A matching encoding that carries the reserved size code raises a one-cycle illegal flag instead of producing results. Element 0 occupies the least significant bits of each vector.

Top module: `lane_permute_unit`

## Requirements
- R1: Lanes are little-endian: element k of width W occupies bits [k*W+W-1 : k*W]. The size field instr_i[19:18] selects the element width: 0 gives 8-bit, 1 gives 16-bit and 2 gives 32-bit elements.
- R2: Zip is decoded when instr_i[17:16]=2, instr_i[11:8]=1, instr_i[7]=1 and instr_i[6]=1. With N elements per vector, result A element 2i is A[i] and element 2i+1 is B[i]. Result B element 2i is A[i+N/2] and element 2i+1 is B[i+N/2].
- R3: Unzip is decoded with the same fields as zip, except that instr_i[7]=0. Result A holds the even elements of A in its low half and the even elements of B in its high half. Result B holds the odd elements in the same arrangement.
- R4: Transpose is decoded when instr_i[17:16]=2 and instr_i[11:6]=3. For every pair i, result A element 2i+1 takes B[2i] and result B element 2i takes A[2i+1]. Every other element is passed through from its own operand.
- R5: A matching encoding with size code 3 sets illegal_o for one cycle. In that cycle valid_o stays low and both results keep their previous values.
- R6: A strobed word that matches none of the three encodings leaves valid_o and illegal_o low and both results unchanged.
- R7: While in_valid_i is low, the instruction word and operands have no effect: valid_o and illegal_o stay low and the results are held.
- R8: The results of a legal strobed operation appear, together with valid_o=1, on the first rising clock edge after the strobe. valid_o then lasts exactly one cycle per strobe.
- R9: An active-low asynchronous reset clears valid_o, illegal_o and both results to zero.
- R10: valid_o and illegal_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation strobe |
| instr_i | input | 32 | Instruction word |
| vec_a_i | input | 128 | First operand |
| vec_b_i | input | 128 | Second operand |
| res_a_o | output | 128 | Result for the first register |
| res_b_o | output | 128 | Result for the second register |
| valid_o | output | 1 | Results updated this cycle |
| illegal_o | output | 1 | Reserved size code on a matching encoding |

## Verification
The hardest situation to reach is a strobed word that almost decodes. Examples are a zip/unzip pattern with a wrong nibble in [11:8], the wrong value in [17:16], or a correct pattern carrying the reserved size code. In each case the block must hold results that were produced earlier, and a held value only shows up at the ports if it differs from what a fresh operation would produce. The stimulus therefore first loads the results with a known random operation. It then strobes these near-miss words with different random operands and compares the outputs against the earlier expected values. Bits outside the decode fields are randomized on every word, so no decision can hinge on them.

// File: rtl/lpu_pkg.sv
package lpu_pkg;
  localparam int VEC_W = 128;
  localparam int INSTR_W = 32;
  localparam int NUM_SZ = 3;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ZIP  = 2'd1,
    OP_UZP  = 2'd2,
    OP_TRN  = 2'd3
  } perm_op_e;

  typedef enum logic [1:0] {
    SZ_8   = 2'd0,
    SZ_16  = 2'd1,
    SZ_32  = 2'd2,
    SZ_BAD = 2'd3
  } elem_sz_e;
endpackage

// File: rtl/lpu_decode.sv
module lpu_decode
  import lpu_pkg::*;
(
  input  logic [3:0] hi_field_i,  // instr[19:16]
  input  logic [5:0] lo_field_i,  // instr[11:6]
  output perm_op_e   op_o,
  output elem_sz_e   sz_o,
  output logic       bad_sz_o
);
  logic grp_ok;
  assign grp_ok = (hi_field_i[1:0] == 2'd2);
  assign sz_o   = elem_sz_e'(hi_field_i[3:2]);

  always_comb begin
    op_o = OP_NONE;
    if (grp_ok) begin
      if (lo_field_i[5:2] == 4'd1 && lo_field_i[0])
        op_o = lo_field_i[1] ? OP_ZIP : OP_UZP;
      else if (lo_field_i == 6'd3)
        op_o = OP_TRN;
    end
  end

  assign bad_sz_o = (op_o != OP_NONE) && (sz_o == SZ_BAD);
endmodule

// File: rtl/lpu_lane_shuffle.sv
module lpu_lane_shuffle
  import lpu_pkg::*;
#(
  parameter int VW = 128,
  parameter int EW = 8
) (
  input  perm_op_e        op_i,
  input  logic [VW-1:0]   a_i,
  input  logic [VW-1:0]   b_i,
  output logic [VW-1:0]   ra_o,
  output logic [VW-1:0]   rb_o
);
  localparam int N = VW / EW;
  localparam int H = N / 2;

  logic [VW-1:0] zip_a, zip_b, uzp_a, uzp_b, trn_a, trn_b;

  for (genvar i = 0; i < H; i++) begin : g_pair
    // zip: low halves into A, high halves into B
    assign zip_a[(2*i)*EW   +: EW] = a_i[i*EW       +: EW];
    assign zip_a[(2*i+1)*EW +: EW] = b_i[i*EW       +: EW];
    assign zip_b[(2*i)*EW   +: EW] = a_i[(i+H)*EW   +: EW];
    assign zip_b[(2*i+1)*EW +: EW] = b_i[(i+H)*EW   +: EW];
    // unzip: even lanes to A, odd lanes to B
    assign uzp_a[i*EW       +: EW] = a_i[(2*i)*EW   +: EW];
    assign uzp_a[(i+H)*EW   +: EW] = b_i[(2*i)*EW   +: EW];
    assign uzp_b[i*EW       +: EW] = a_i[(2*i+1)*EW +: EW];
    assign uzp_b[(i+H)*EW   +: EW] = b_i[(2*i+1)*EW +: EW];
    // transpose: swap A odd with B even
    assign trn_a[(2*i)*EW   +: EW] = a_i[(2*i)*EW   +: EW];
    assign trn_a[(2*i+1)*EW +: EW] = b_i[(2*i)*EW   +: EW];
    assign trn_b[(2*i)*EW   +: EW] = a_i[(2*i+1)*EW +: EW];
    assign trn_b[(2*i+1)*EW +: EW] = b_i[(2*i+1)*EW +: EW];
  end

  always_comb begin
    unique case (op_i)
      OP_ZIP:  begin ra_o = zip_a; rb_o = zip_b; end
      OP_UZP:  begin ra_o = uzp_a; rb_o = uzp_b; end
      OP_TRN:  begin ra_o = trn_a; rb_o = trn_b; end
      default: begin ra_o = a_i;   rb_o = b_i;   end
    endcase
  end
endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit
  import lpu_pkg::*;
#(
  parameter int VW = VEC_W,
  parameter int IW = INSTR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [IW-1:0] instr_i,
  input  logic [VW-1:0] vec_a_i,
  input  logic [VW-1:0] vec_b_i,
  output logic [VW-1:0] res_a_o,
  output logic [VW-1:0] res_b_o,
  output logic          valid_o,
  output logic          illegal_o
);
  perm_op_e op;
  elem_sz_e sz;
  logic     bad_sz;
  logic     unused_bits;

  assign unused_bits = ^{instr_i[IW-1:20], instr_i[15:12], instr_i[5:0]};

  lpu_decode u_dec (
    .hi_field_i (instr_i[19:16]),
    .lo_field_i (instr_i[11:6]),
    .op_o       (op),
    .sz_o       (sz),
    .bad_sz_o   (bad_sz)
  );

  logic [VW-1:0] sh_a [NUM_SZ];
  logic [VW-1:0] sh_b [NUM_SZ];

  for (genvar g = 0; g < NUM_SZ; g++) begin : g_width
    lpu_lane_shuffle #(.VW(VW), .EW(8 << g)) u_shuf (
      .op_i (op),
      .a_i  (vec_a_i),
      .b_i  (vec_b_i),
      .ra_o (sh_a[g]),
      .rb_o (sh_b[g])
    );
  end

  logic [VW-1:0] sel_a, sel_b;
  always_comb begin
    unique case (sz)
      SZ_16:   begin sel_a = sh_a[1]; sel_b = sh_b[1]; end
      SZ_32:   begin sel_a = sh_a[2]; sel_b = sh_b[2]; end
      default: begin sel_a = sh_a[0]; sel_b = sh_b[0]; end
    endcase
  end

  logic take, flag_bad;
  assign take     = in_valid_i && (op != OP_NONE) && !bad_sz;
  assign flag_bad = in_valid_i && bad_sz;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_a_o   <= '0;
      res_b_o   <= '0;
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      valid_o   <= take;
      illegal_o <= flag_bad;
      if (take) begin
        res_a_o <= sel_a;
        res_b_o <= sel_b;
      end
    end
  end

  assert_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && illegal_o));

  assert_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(in_valid_i));

  assert_illegal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> ($past(instr_i[19:18]) == 2'd3) && $past(in_valid_i));

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(res_a_o) && $stable(res_b_o)));

  // every permutation keeps A lane 0 and B top lane in place
  assert_lane_ends_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (res_a_o[7:0] == $past(vec_a_i[7:0])) &&
                (res_b_o[VW-1 -: 8] == $past(vec_b_i[VW-1 -: 8])));
endmodule

// File: tb/lane_permute_unit_bench.sv
module lane_permute_unit_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid_i = 1'b0;
  logic [31:0]  instr_i = '0;
  logic [127:0] vec_a_i = '0, vec_b_i = '0;
  logic [127:0] res_a_o, res_b_o;
  logic         valid_o, illegal_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  lane_permute_unit u_lane_permute_unit (
    .clk_i, .rst_ni, .in_valid_i, .instr_i, .vec_a_i, .vec_b_i,
    .res_a_o, .res_b_o, .valid_o, .illegal_o
  );

  localparam int ZIP = 0, UZP = 1, TRN = 2;
  logic [127:0] exp_a, exp_b;

  function automatic logic [31:0] el(logic [127:0] v, int k, int w);
    logic [127:0] m = (128'd1 << w) - 128'd1;
    return 32'((v >> (k * w)) & m);
  endfunction

  function automatic logic [127:0] put(logic [127:0] v, int k, int w, logic [31:0] x);
    logic [127:0] m = ((128'd1 << w) - 128'd1) << (k * w);
    return (v & ~m) | ((128'(x) << (k * w)) & m);
  endfunction

  task automatic ref_model(input int op, input int w, input logic [127:0] a, b,
                           output logic [127:0] ra, rb);
    int n = 128 / w;
    int h = n / 2;
    ra = '0; rb = '0;
    if (op == TRN) begin
      ra = a; rb = b;
      for (int k = 0; k < n; k += 2) begin
        ra = put(ra, k + 1, w, el(b, k, w));
        rb = put(rb, k, w, el(a, k + 1, w));
      end
    end else begin
      for (int k = 0; k < n; k++) begin
        if (op == ZIP) begin
          ra = put(ra, k, w, (k % 2 == 0) ? el(a, k / 2, w) : el(b, k / 2, w));
          rb = put(rb, k, w, (k % 2 == 0) ? el(a, k / 2 + h, w) : el(b, k / 2 + h, w));
        end else if (k < h) begin
          ra = put(ra, k, w, el(a, 2 * k, w));
          rb = put(rb, k, w, el(a, 2 * k + 1, w));
        end else begin
          ra = put(ra, k, w, el(b, 2 * (k - h), w));
          rb = put(rb, k, w, el(b, 2 * (k - h) + 1, w));
        end
      end
    end
  endtask

  function automatic logic [31:0] mk(int op, logic [1:0] sz);
    logic [31:0] w = $urandom;
    w[19:16] = {sz, 2'b10};
    case (op)
      ZIP:     w[11:6] = 6'b000111;
      UZP:     w[11:6] = 6'b000101;
      default: w[11:6] = 6'b000011;
    endcase
    return w;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one strobe at negedge, sample at the following negedge
  task automatic issue(input logic [31:0] ins, input logic [127:0] a, b, input logic strobe);
    @(negedge clk_i);
    instr_i = ins; vec_a_i = a; vec_b_i = b; in_valid_i = strobe;
    @(negedge clk_i);
    in_valid_i = 1'b0; instr_i = $urandom; vec_a_i = rnd128(); vec_b_i = rnd128();
  endtask

  task automatic t_reset();
    chk("R9", "valid after reset", 128'(valid_o), 128'd0);
    chk("R9", "illegal after reset", 128'(illegal_o), 128'd0);
    chk("R9", "res_a after reset", res_a_o, '0);
    chk("R9", "res_b after reset", res_b_o, '0);
  endtask

  task automatic t_op(input int op, input string req, input int reps);
    for (int s = 0; s < 3; s++) begin
      for (int r = 0; r < reps; r++) begin
        logic [127:0] a = rnd128(), b = rnd128();
        ref_model(op, 8 << s, a, b, exp_a, exp_b);
        issue(mk(op, 2'(s)), a, b, 1'b1);
        chk(req, "res_a", res_a_o, exp_a);
        chk(req, "res_b", res_b_o, exp_b);
        chk("R8", "valid one cycle after strobe", 128'(valid_o), 128'd1);
        chk("R10", "illegal with valid", 128'(illegal_o), 128'd0);
        @(negedge clk_i);
        chk("R8", "valid drops after one cycle", 128'(valid_o), 128'd0);
      end
    end
  endtask

  task automatic t_lane_order();
    logic [127:0] a, b;
    for (int k = 0; k < 16; k++) begin
      a[k*8 +: 8] = 8'(k);
      b[k*8 +: 8] = 8'(8'h80 + k);
    end
    issue(mk(ZIP, 2'd0), a, b, 1'b1);
    chk("R1", "8-bit zip lane order A",
        res_a_o, 128'h87078606850584048303820281018000);
    chk("R1", "8-bit zip lane order B",
        res_b_o, 128'h8f0f8e0e8d0d8c0c8b0b8a0a89098808);
    issue(mk(UZP, 2'd2), a, b, 1'b1);
    chk("R1", "32-bit unzip lane order A",
        res_a_o, 128'h8b8a898883828180_0b0a090803020100);
  endtask

  task automatic t_illegal();
    for (int op = 0; op < 3; op++) begin
      logic [127:0] a = rnd128(), b = rnd128();
      ref_model(op, 16, a, b, exp_a, exp_b);
      issue(mk(op, 2'd1), a, b, 1'b1);
      issue(mk(op, 2'd3), rnd128(), rnd128(), 1'b1);
      chk("R5", "illegal flag", 128'(illegal_o), 128'd1);
      chk("R5", "valid low on illegal", 128'(valid_o), 128'd0);
      chk("R5", "res_a held", res_a_o, exp_a);
      chk("R5", "res_b held", res_b_o, exp_b);
      @(negedge clk_i);
      chk("R5", "illegal lasts one cycle", 128'(illegal_o), 128'd0);
    end
  endtask

  task automatic t_unmatched();
    logic [31:0] bad [4];
    logic [127:0] a = rnd128(), b = rnd128();
    ref_model(TRN, 32, a, b, exp_a, exp_b);
    issue(mk(TRN, 2'd2), a, b, 1'b1);
    bad[0] = mk(ZIP, 2'd0); bad[0][17:16] = 2'b01;
    bad[1] = mk(UZP, 2'd1); bad[1][11:8] = 4'h2;
    bad[2] = mk(ZIP, 2'd2); bad[2][6] = 1'b0;
    bad[3] = mk(TRN, 2'd3); bad[3][17:16] = 2'b00;
    for (int i = 0; i < 4; i++) begin
      issue(bad[i], rnd128(), rnd128(), 1'b1);
      chk("R6", "valid on unmatched", 128'(valid_o), 128'd0);
      chk("R6", "illegal on unmatched", 128'(illegal_o), 128'd0);
      chk("R6", "res_a held", res_a_o, exp_a);
      chk("R6", "res_b held", res_b_o, exp_b);
    end
  endtask

  task automatic t_no_strobe();
    for (int op = 0; op < 3; op++) begin
      issue(mk(op, 2'(op)), rnd128(), rnd128(), 1'b0);
      chk("R7", "valid without strobe", 128'(valid_o), 128'd0);
      chk("R7", "illegal without strobe", 128'(illegal_o), 128'd0);
      chk("R7", "res_a held", res_a_o, exp_a);
      chk("R7", "res_b held", res_b_o, exp_b);
    end
    issue(mk(ZIP, 2'd3), rnd128(), rnd128(), 1'b0);
    chk("R7", "no illegal flag without strobe", 128'(illegal_o), 128'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_lane_order();
    t_op(ZIP, "R2", 4);
    t_op(UZP, "R3", 4);
    t_op(TRN, "R4", 4);
    t_illegal();
    t_unmatched();
    t_no_strobe();
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    t_reset();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule